// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Interface

This block is the bus-facing register logic in front of four 12-bit digital-to-analog converters. Software writes each channel's next code as two pieces over a synchronous write bus: an 8-bit low part and a 4-bit high part. Both pieces land in per-channel staging registers. The converters never see these staging registers directly. A write to a dedicated commit address copies all four staged codes into the output registers on one clock edge, so the four analog outputs change together.

A single enable bit gates the output switches of all four channels at once. Reset clears this bit, so the switches stay open until software has loaded sensible codes and enabled them. The enable bit is set or cleared through a write-only control port. The port takes an enable command only when a command-select bit in the written word is 1; it ignores other control words.

Top module: `quad_dac_regs`

## Requirements
- R1: A write to address 2c (c = 0..3) stores wr_data[7:0] into channel c's low staging register. A write to address 2c+1 stores wr_data[3:0] into channel c's high staging register. All other data bits are ignored.
- R2: Staging writes never change dac_code on their own. dac_code changes only on the edge that samples a commit write.
- R3: A write to address 0x10 copies all four staged codes into dac_code on the edge that samples it, and the four channels update together. The data word of the commit write is ignored.
- R4: Channel c drives dac_code[12c+11:12c]. Its high staging nibble becomes bits 11:8 and its low staging byte becomes bits 7:0.
- R5: While rst is high, the enable bit, sw_en, dac_code and all staging registers are cleared to 0.
- R6: A write to address 0x40 with wr_data[11] = 1 loads wr_data[15] into the enable bit. sw_en shows the new value on every bit from the edge that samples the write.
- R7: A write to address 0x40 with wr_data[11] = 0 leaves sw_en unchanged, whatever wr_data[15] is.
- R8: The bits of sw_en are always all 0 or all 1.
- R9: A write to any address not named in R1, R3 or R6 changes no staging register, no dac_code bit and no sw_en bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one bus write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| dac_code | output | 48 | Four 12-bit converter codes; channel c at bits 12c+11:12c |
| sw_en | output | 4 | Per-channel output switch enables |

## Verification
Every visible result appears exactly one clock edge after the write that causes it. A commit write shows on dac_code, and an enable command shows on sw_en, at the first edge that samples the write. A staging write has no effect on the ports until a later commit. The bench drives inputs on falling edges and keeps a behavioural model that it advances on rising edges. It compares both output buses with the model at every falling edge, after the rising edge that carried the write. Directed checks sample at that same falling edge to confirm the staged values before and after a commit, the two kinds of control word, and writes to unmapped addresses.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  // control word field positions (decoded by the enable logic)
  localparam int CTRL_SEL_BIT = 11;
  localparam int CTRL_VAL_BIT = 15;

  typedef struct packed {
    logic lo;
    logic hi;
  } stage_sel_t;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import quad_dac_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int STAGE_BASE = 'h00,
  parameter int LOAD_ADDR  = 'h10,
  parameter int CTRL_ADDR  = 'h40
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output stage_sel_t [NUM_CH-1:0] stage_sel,
  output logic              load_hit,
  output logic              ctrl_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO_A = STAGE_BASE + 2 * c;
    localparam int HI_A = STAGE_BASE + 2 * c + 1;
    always_comb begin
      stage_sel[c].lo = wr_en && (wr_addr == ADDR_W'(LO_A));
      stage_sel[c].hi = wr_en && (wr_addr == ADDR_W'(HI_A));
    end
  end

  always_comb begin
    load_hit = wr_en && (wr_addr == ADDR_W'(LOAD_ADDR));
    ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int CODE_W = 12,
  parameter int LO_W   = 8,
  localparam int HI_W  = CODE_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              commit,
  input  logic [LO_W-1:0]   din_lo,
  input  logic [HI_W-1:0]   din_hi,
  output logic [CODE_W-1:0] code
);
  logic [LO_W-1:0] stage_lo;
  logic [HI_W-1:0] stage_hi;

  // staging pair
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      stage_hi <= '0;
    end else begin
      if (lo_wr) stage_lo <= din_lo;
      if (hi_wr) stage_hi <= din_hi;
    end
  end

  // output register feeding the converter
  always_ff @(posedge clk) begin
    if (rst)         code <= '0;
    else if (commit) code <= {stage_hi, stage_lo};
  end
endmodule

// File: rtl/dac_enable_ctrl.sv
module dac_enable_ctrl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_hit,
  input  logic              cmd_sel,
  input  logic              cmd_val,
  output logic [NUM_CH-1:0] sw_en
);
  logic take;
  assign take = ctrl_hit && cmd_sel;

  // one flop per switch, all loaded from the same command
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sw
    always_ff @(posedge clk) begin
      if (rst)       sw_en[c] <= 1'b0;
      else if (take) sw_en[c] <= cmd_val;
    end
  end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import quad_dac_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CODE_W     = 12,
  parameter int LO_W       = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int STAGE_BASE = 'h00,
  parameter int LOAD_ADDR  = 'h10,
  parameter int CTRL_ADDR  = 'h40,
  localparam int HI_W      = CODE_W - LO_W,
  localparam int BUS_W     = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BUS_W-1:0]  dac_code,
  output logic [NUM_CH-1:0] sw_en
);
  stage_sel_t [NUM_CH-1:0] stage_sel;
  logic load_hit;
  logic ctrl_hit;
  logic unused_data;

  assign unused_data = ^wr_data;

  dac_wr_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STAGE_BASE(STAGE_BASE),
    .LOAD_ADDR(LOAD_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .stage_sel(stage_sel), .load_hit(load_hit), .ctrl_hit(ctrl_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dac_channel #(.CODE_W(CODE_W), .LO_W(LO_W)) u_chan (
      .clk(clk), .rst(rst),
      .lo_wr(stage_sel[c].lo), .hi_wr(stage_sel[c].hi),
      .commit(load_hit),
      .din_lo(wr_data[LO_W-1:0]), .din_hi(wr_data[HI_W-1:0]),
      .code(dac_code[c*CODE_W +: CODE_W])
    );
  end

  dac_enable_ctrl #(.NUM_CH(NUM_CH)) u_en (
    .clk(clk), .rst(rst), .ctrl_hit(ctrl_hit),
    .cmd_sel(wr_data[CTRL_SEL_BIT]), .cmd_val(wr_data[CTRL_VAL_BIT]),
    .sw_en(sw_en)
  );
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk #(
  parameter int NUM_CH    = 4,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LOAD_ADDR = 'h10,
  parameter int CTRL_ADDR = 'h40,
  localparam int BUS_W    = NUM_CH * CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BUS_W-1:0]  dac_code,
  input logic [NUM_CH-1:0] sw_en
);
  logic unused_bits;
  logic is_load, is_ctrl;
  assign unused_bits = ^wr_data;
  assign is_load = wr_en && (wr_addr == ADDR_W'(LOAD_ADDR));
  assign is_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  assert_reset_off_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_en == '0 && dac_code == '0));

  assert_uniform_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_en == '0) || (sw_en == '1));

  assert_hold_code_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(is_load)) |-> $stable(dac_code));

  assert_enable_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_ctrl && wr_data[11]))
      |-> (sw_en == {NUM_CH{$past(wr_data[15])}}));

  assert_ignore_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_ctrl && !wr_data[11])) |-> $stable(sw_en));

  assert_other_wr_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(is_ctrl)) |-> $stable(sw_en));
endmodule

bind quad_dac_regs quad_dac_regs_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .LOAD_ADDR(LOAD_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .dac_code(dac_code), .sw_en(sw_en)
);

// File: tb/quad_dac_regs_tb.sv
`timescale 1ns/100ps
module quad_dac_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [47:0] dac_code;
  logic [3:0]  sw_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_dac_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dac_code(dac_code), .sw_en(sw_en)
  );

  // behavioural reference
  logic [7:0]  m_lo [4];
  logic [3:0]  m_hi [4];
  logic [11:0] m_out[4];
  logic        m_en;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_out[i] = 0;
      end
      m_en = 0;
    end else if (wr_en) begin
      if (wr_addr < 8) begin
        if (wr_addr[0]) m_hi[wr_addr[2:1]] = wr_data[3:0];
        else            m_lo[wr_addr[2:1]] = wr_data[7:0];
      end else if (wr_addr == 8'h10) begin
        for (int i = 0; i < 4; i++) m_out[i] = {m_hi[i], m_lo[i]};
      end else if (wr_addr == 8'h40 && wr_data[11]) begin
        m_en = wr_data[15];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 code vs model", dac_code, {m_out[3], m_out[2], m_out[1], m_out[0]});
      chk("R6 enable vs model", sw_en, {4{m_en}});
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 8'hEE; wr_data = 16'h0;
  endtask

  logic [47:0] saved;
  logic [15:0] lf;

  initial begin
    repeat (4) @(negedge clk);
    chk("R5 reset code", dac_code, 48'h0);
    chk("R5 reset enable", sw_en, 4'h0);
    rst = 1'b0;

    // R1 staging with garbage in upper data bits
    bus_wr(8'h00, 16'hFFA5); bus_wr(8'h01, 16'hFFF3);
    bus_wr(8'h02, 16'h7E5C); bus_wr(8'h03, 16'h00F9);
    bus_wr(8'h04, 16'h1201); bus_wr(8'h05, 16'hAB60);
    bus_wr(8'h06, 16'h33FF); bus_wr(8'h07, 16'h000F);
    chk("R2 staging does not reach outputs", dac_code, 48'h0);

    // R3 commit with arbitrary data; R4 bit placement; R1 stored fields
    bus_wr(8'h10, 16'hBEEF);
    chk("R3 R4 R1 commit all channels", dac_code, {12'hFFF, 12'h001, 12'h95C, 12'h3A5});

    // R2 stage new value, outputs hold until next commit
    bus_wr(8'h00, 16'h0011);
    chk("R2 hold after staging", dac_code[11:0], 12'h3A5);
    bus_wr(8'h10, 16'h0000);
    chk("R3 second commit", dac_code[11:0], 12'h311);

    // R6 enable and R8 uniform
    bus_wr(8'h40, 16'h8800);
    chk("R6 enable on", sw_en, 4'hF);
    chk("R8 uniform", (sw_en == 4'h0 || sw_en == 4'hF), 1);
    // R7 control words without select bit
    bus_wr(8'h40, 16'h0000);
    chk("R7 ignore select clear", sw_en, 4'hF);
    bus_wr(8'h40, 16'h0000);
    bus_wr(8'h40, 16'h0800);
    chk("R6 enable off", sw_en, 4'h0);
    bus_wr(8'h40, 16'h8000);
    chk("R7 ignore bit15 without select", sw_en, 4'h0);

    // R9 unmapped addresses
    saved = dac_code;
    bus_wr(8'h08, 16'hFFFF); bus_wr(8'h11, 16'h8800);
    bus_wr(8'h41, 16'h8800); bus_wr(8'hFF, 16'hFFFF);
    chk("R9 unmapped leaves enable", sw_en, 4'h0);
    bus_wr(8'h10, 16'h1234);
    chk("R9 unmapped leaves staging", dac_code, saved);

    // mixed traffic, compared every cycle by the model
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[11:9])
        3'd5:    a = 8'h10;
        3'd6:    a = 8'h40;
        3'd7:    a = 8'h20 + {3'b0, lf[4:0]};
        default: a = {5'b0, lf[2:0]};
      endcase
      bus_wr(a, {lf[7:0], lf[15:8]});
    end

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    done = 1;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule